// File: doc/BRIEF.md
# Multipurpose Pin Controller with Combined Interrupt

This block manages a bank of general-purpose pins (eight by default). For every pin, software chooses through a small register bus whether it is an input or an output. An output pin is driven high or low, or its driver is released so the line can be shared. An input pin's level is sampled and can be reported inverted. An enabled input can request an interrupt. Pad cells stay outside the block: it produces an output-enable and an output-data bit per pin, and it receives the raw pad levels, which it resynchronises before use.

All per-pin interrupt requests are level-sensitive and are ORed onto one host interrupt line. A separate timer-select input hands pin 0 to an external timer signal. While timer-select is high, pin 0 drives that signal with its driver forced on, never requests an interrupt and reports its level without inversion, whatever its five control bits hold. Those bits are kept, and they take effect again when timer-select falls.

The register bus is plain control traffic with no back-pressure. A write completes in the cycle its strobe is sampled. Reads are combinational from the address. No stream interface exists at the block's edge, so there is no valid/ready pair.

Top module: `gpx_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, all five control registers read 0. Every pin is then an un-inverted input with its interrupt disabled, the output enables for pins 7..1 are 0, and `irq` is 0.
- R2: The register addresses are 0 for direction (1 = output), 1 for output level, 2 for driver-off (1 = released), 3 for input invert and 4 for interrupt enable. A write with `wr_en` high stores `wdata` into the addressed register, and it reads back on `rdata` from the next cycle. Writes to addresses 5..7 change no register, and reads of addresses 6 and 7 return 0.
- R3: Outside timer mode, `pad_oe[i]` is 1 exactly when direction bit i is 1 and driver-off bit i is 0, and `pad_do[i]` equals level bit i.
- R4: Address 5 is read-only. It returns each pin's synchronised pad level XOR its invert bit. A pad change first shows there two clock edges after it is sampled.
- R5: `irq` is the OR over all pins of (direction bit 0, enable bit 1 and reported level 1). It follows the synchronised level with the same two-edge delay as R4.
- R6: While `tmr_sel` is 1, `pad_oe[0]` is 1, `pad_do[0]` equals `tmr_in`, pin 0 adds nothing to `irq`, and bit 0 of address 5 shows the uninverted synchronised pad level.
- R7: Timer mode leaves pin 0's register bits unchanged. After `tmr_sel` falls, pin 0 again follows them for output enable, output data, inversion and interrupt.
- R8: A pin whose direction bit is 1 never contributes to `irq`, even when its enable bit is 1 and its reported level is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data, combinational from `addr` |
| pad_in | input | 8 | Raw pad input levels |
| pad_oe | output | 8 | Per-pin driver enable |
| pad_do | output | 8 | Per-pin driven level |
| tmr_sel | input | 1 | Hands pin 0 to the timer signal |
| tmr_in | input | 1 | External timer output |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench watches the two-edge synchroniser latency. A design that skips a stage, or reads the raw pad, moves `irq` and the status register one cycle too early. It enables interrupts on output pins, so a design that leaves out the direction gate raises a false interrupt. Timer mode is entered with pin 0 inverted, enabled and asserting, so a design that lets the invert bit, the driver-off bit or the enable bit leak through timer mode shows a wrong `pad_oe[0]`, a wrong status bit or a spurious interrupt. Writes to the read-only and unused addresses are checked against readback, which catches an address decoder that aliases them onto a real register.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int unsigned GPX_NREG = 5;
  localparam int unsigned GPX_AW   = 3;

  typedef enum logic [GPX_AW-1:0] {
    GPX_A_DIR = 3'd0,
    GPX_A_LVL = 3'd1,
    GPX_A_OFF = 3'd2,
    GPX_A_INV = 3'd3,
    GPX_A_IEN = 3'd4,
    GPX_A_PIN = 3'd5
  } gpx_addr_e;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else if (s == 0) chain[s] <= d;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpx_regs.sv
module gpx_regs
  import gpx_pkg::*;
#(
  parameter int unsigned PINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [GPX_AW-1:0] addr,
  input  logic [PINS-1:0]   wdata,
  output logic [PINS-1:0]   dir,
  output logic [PINS-1:0]   lvl,
  output logic [PINS-1:0]   off,
  output logic [PINS-1:0]   inv,
  output logic [PINS-1:0]   ien
);
  logic [PINS-1:0] bank [GPX_NREG];

  for (genvar r = 0; r < GPX_NREG; r++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bank[r] <= '0;
      else if (wr_en && (addr == GPX_AW'(r))) bank[r] <= wdata;
    end
  end

  assign dir = bank[GPX_A_DIR];
  assign lvl = bank[GPX_A_LVL];
  assign off = bank[GPX_A_OFF];
  assign inv = bank[GPX_A_INV];
  assign ien = bank[GPX_A_IEN];
endmodule

// File: rtl/gpx_pin.sv
module gpx_pin #(
  parameter bit TMR_CAP = 1'b0
) (
  input  logic dir,
  input  logic lvl,
  input  logic off,
  input  logic inv,
  input  logic ien,
  input  logic pin_s,
  input  logic tmr_sel,
  input  logic tmr_in,
  output logic oe,
  output logic dout,
  output logic status,
  output logic req
);
  logic takeover;

  if (TMR_CAP) begin : g_tmr
    assign takeover = tmr_sel;
  end else begin : g_plain
    assign takeover = 1'b0;
  end

  always_comb begin
    if (takeover) begin
      oe     = 1'b1;
      dout   = tmr_in;
      status = pin_s;
      req    = 1'b0;
    end else begin
      oe     = dir & ~off;
      dout   = lvl;
      status = pin_s ^ inv;
      req    = ~dir & ien & status;
    end
  end
endmodule

// File: rtl/gpx_ctrl.sv
module gpx_ctrl
  import gpx_pkg::*;
#(
  parameter int unsigned PINS    = 8,
  parameter int unsigned SYNC    = 2,
  parameter int unsigned TMR_PIN = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [GPX_AW-1:0] addr,
  input  logic [PINS-1:0]   wdata,
  output logic [PINS-1:0]   rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_oe,
  output logic [PINS-1:0]   pad_do,
  input  logic              tmr_sel,
  input  logic              tmr_in,
  output logic              irq
);
  logic [PINS-1:0] dir, lvl, off, inv, ien;
  logic [PINS-1:0] pin_s, status, req;

  gpx_regs #(.PINS(PINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .dir(dir), .lvl(lvl), .off(off), .inv(inv), .ien(ien)
  );

  gpx_sync #(.W(PINS), .STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_s)
  );

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    gpx_pin #(.TMR_CAP(i == TMR_PIN)) u_pin (
      .dir(dir[i]), .lvl(lvl[i]), .off(off[i]), .inv(inv[i]), .ien(ien[i]),
      .pin_s(pin_s[i]), .tmr_sel(tmr_sel), .tmr_in(tmr_in),
      .oe(pad_oe[i]), .dout(pad_do[i]), .status(status[i]), .req(req[i])
    );
  end

  assign irq = |req;

  always_comb begin
    unique case (addr)
      GPX_A_DIR: rdata = dir;
      GPX_A_LVL: rdata = lvl;
      GPX_A_OFF: rdata = off;
      GPX_A_INV: rdata = inv;
      GPX_A_IEN: rdata = ien;
      GPX_A_PIN: rdata = status;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpx_ctrl_chk.sv
module gpx_ctrl_chk #(
  parameter int unsigned PINS = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [2:0]      addr,
  input logic [PINS-1:0] wdata,
  input logic [PINS-1:0] rdata,
  input logic [PINS-1:0] pad_oe,
  input logic [PINS-1:0] pad_do,
  input logic            tmr_sel,
  input logic            tmr_in,
  input logic            irq,
  input logic [PINS-1:0] dir,
  input logic [PINS-1:0] ien
);
  // R1: quiet outputs while in reset
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!irq && pad_oe[PINS-1:1] == '0);
    end
  end

  // R2: a register write is visible on readback the next cycle at the same address
  assert_wr_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr < 3'd5) |=> ((addr != $past(addr)) || (rdata == $past(wdata))));

  // R6: the timer owns pin 0
  assert_tmr_pin0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_sel |-> (pad_oe[0] && pad_do[0] == tmr_in));

  // R5: no interrupt without some enabled input pin
  assert_irq_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((ien & ~dir) != '0));

  // R8: all pins outputs means no interrupt
  assert_out_no_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (&dir) |-> !irq);
endmodule

bind gpx_ctrl gpx_ctrl_chk #(.PINS(PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .pad_oe(pad_oe), .pad_do(pad_do), .tmr_sel(tmr_sel),
  .tmr_in(tmr_in), .irq(irq), .dir(dir), .ien(ien)
);

// File: tb/gpx_ctrl_tb.sv
`timescale 1ns/1ps
module gpx_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic [7:0] pad_in = 8'd0;
  logic [7:0] pad_oe, pad_do;
  logic       tmr_sel = 1'b0;
  logic       tmr_in = 1'b0;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  gpx_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pad_in(pad_in), .pad_oe(pad_oe), .pad_do(pad_do),
    .tmr_sel(tmr_sel), .tmr_in(tmr_in), .irq(irq)
  );

  // behavioural reference
  logic [7:0] m_reg [5];
  logic [7:0] m_q [$];

  function automatic logic [7:0] m_sync();
    return (m_q.size() >= 2) ? m_q[1] : 8'd0;
  endfunction

  function automatic logic [7:0] m_status();
    logic [7:0] s = m_sync();
    for (int i = 0; i < 8; i++)
      if (!(tmr_sel && i == 0)) s[i] = s[i] ^ m_reg[3][i];
    return s;
  endfunction

  function automatic logic m_irq();
    logic [7:0] s = m_status();
    logic r = 1'b0;
    for (int i = 0; i < 8; i++)
      if (!(tmr_sel && i == 0) && !m_reg[0][i] && m_reg[4][i] && s[i]) r = 1'b1;
    return r;
  endfunction

  function automatic logic [7:0] m_oe();
    logic [7:0] o;
    for (int i = 0; i < 8; i++) o[i] = m_reg[0][i] && !m_reg[2][i];
    if (tmr_sel) o[0] = 1'b1;
    return o;
  endfunction

  function automatic logic [7:0] m_do();
    logic [7:0] o = m_reg[1];
    if (tmr_sel) o[0] = tmr_in;
    return o;
  endfunction

  function automatic logic [7:0] m_rdata();
    if (addr < 3'd5) return m_reg[addr];
    if (addr == 3'd5) return m_status();
    return 8'd0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < 5; r++) m_reg[r] <= 8'd0;
      m_q = {};
    end else begin
      if (wr_en && addr < 3'd5) m_reg[addr] <= wdata;
      m_q.push_front(pad_in);
      if (m_q.size() > 2) void'(m_q.pop_back());
    end
  end

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // compare on every clock, 2 ns after the edge
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk((addr == 3'd5) ? "R4" : "R2", "rdata", rdata, m_rdata());
      chk("R3", "pad_oe", pad_oe, m_oe());
      chk("R3", "pad_do", pad_do, m_do());
      chk("R5", "irq", {7'd0, irq}, {7'd0, m_irq()});
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, string req, logic [7:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    chk(req, "read", rdata, exp);
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      finish_up();
    end
  end

  initial begin
    #1;
    // R1: reset state
    chk("R1", "oe in reset", pad_oe, 8'd0);
    chk("R1", "irq in reset", {7'd0, irq}, 8'd0);
    tick(3);
    rst_n = 1'b1;
    for (int a = 0; a < 8; a++) rd(3'(a), "R1", 8'd0);

    // R2: write and readback, ignored addresses
    wr(3'd4, 8'h5A); rd(3'd4, "R2", 8'h5A);
    wr(3'd4, 8'h00);
    wr(3'd5, 8'hFF); wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
    for (int a = 0; a < 5; a++) rd(3'(a), "R2", 8'd0);
    rd(3'd6, "R2", 8'd0); rd(3'd7, "R2", 8'd0);

    // R3: direction, driver-off, level
    wr(3'd0, 8'hF0); wr(3'd2, 8'h30); wr(3'd1, 8'hA5);
    tick(1);
    chk("R3", "oe gating", pad_oe, 8'hC0);
    chk("R3", "do level", pad_do, 8'hA5);

    // R4: inversion and two-edge latency
    wr(3'd3, 8'h0F);
    addr = 3'd5;
    pad_in = 8'h33;
    tick(1); #1;
    chk("R4", "status after one edge", rdata, 8'h0F);
    tick(1); #1;
    chk("R4", "status after two edges", rdata, 8'h3C);

    // R5: enabled input interrupt, level-sensitive
    wr(3'd4, 8'h01);
    tick(1);
    chk("R5", "pin0 inverted low no irq", {7'd0, irq}, 8'd0);
    pad_in = 8'h32;
    tick(1); #1;
    chk("R5", "irq not yet", {7'd0, irq}, 8'd0);
    tick(1); #1;
    chk("R5", "irq raised", {7'd0, irq}, 8'd1);

    // R8: output pin with enable and high status gives nothing
    wr(3'd4, 8'h80);
    pad_in = 8'hB3;
    tick(3);
    chk("R8", "output pin no irq", {7'd0, irq}, 8'd0);

    // R6: timer mode on pin 0 while pin 0 requests
    wr(3'd4, 8'h01); wr(3'd2, 8'h31);
    pad_in = 8'h32;
    tick(3);
    chk("R5", "pin0 request before timer", {7'd0, irq}, 8'd1);
    tmr_sel = 1'b1; tmr_in = 1'b1; addr = 3'd5;
    #1;
    chk("R6", "oe0 forced", {7'd0, pad_oe[0]}, 8'd1);
    chk("R6", "do0 timer", {7'd0, pad_do[0]}, 8'd1);
    chk("R6", "no pin0 irq", {7'd0, irq}, 8'd0);
    chk("R6", "status0 raw", {7'd0, rdata[0]}, 8'd0);
    for (int k = 0; k < 6; k++) begin
      tmr_in = ~tmr_in;
      tick(1);
    end
    wr(3'd3, 8'h00);
    wr(3'd3, 8'h0F);

    // R7: leaving timer mode restores pin 0 settings
    rd(3'd2, "R7", 8'h31);
    tmr_sel = 1'b0;
    #1;
    chk("R7", "oe0 from regs", {7'd0, pad_oe[0]}, 8'd0);
    chk("R7", "irq back", {7'd0, irq}, 8'd1);
    rd(3'd5, "R7", 8'h3D);
    tick(4);
    finish_up();
  end
endmodule